// File: doc/BRIEF.md
# Tuner Synthesizer Control Slave

This block is a two-wire serial slave that sits in front of a frequency-synthesizer loop in a tuner. A bus master writes the main and swallow divider values, the reference-divider code, the prescaler-halving enable, the charge-pump current select, the varicap-drive disable and four general port bits. The master can also read back one status byte. That byte carries a power-up flag, the loop lock indication and a 3-bit level code from an external converter.

SCL and SDA are sampled by a fast system clock through two-flop synchronizers. All bus edges are found on the synchronized copies. SDA is driven open-drain: the block only ever pulls the line low. After a matched address, the block sorts each data byte by its top bit, into a two-byte frequency group or a two-byte control group. The two frequency bytes reach the outputs together. Each control byte takes effect on its own. A transfer cut short leaves the earlier settings in force. This makes a three-byte frequency-only command a complete update.

Top module: `tuner_ctl_i2c_slave`

## Requirements
- R1: Reset clears every programmed output to 0, releases SDA (sda_oe=0) and sets the power-up flag to 1.
- R2: The slave responds only to an address byte whose seven upper bits are 1,1,0,0,0,addr_sel[1],addr_sel[0]. Bit 0 of the address byte is 0 for write and 1 for read. Any other address gets no acknowledge and changes no output.
- R3: Every byte written to a matched address, the address byte included, is acknowledged by pulling SDA low during the ninth SCL clock.
- R4: The frequency group has two bytes. The first is {0, M[10:4]}. The second is {M[3:0], S[3:0]}. main_ratio[10:0] and swallow update together, and only after the second byte.
- R5: Control byte A is {1, M[12:11], PE, R[3:0]}. It updates main_ratio[12:11], pre_half and ref_code as soon as it is received.
- R6: Control byte B is the byte right after control byte A. Its layout is {OS, CP, x, x, P[3:0]}. It updates vari_off, cp_hi and port_bits as soon as it is received.
- R7: If a transfer ends after only the first frequency byte, every output keeps its earlier value.
- R8: A start condition with no stop before it, followed by a matched address, begins a new transfer.
- R9: A read returns the status byte {PF, lock_i, 1, 1, 1, conv_code[2:0]}, MSB first, where PF is the power-up flag. The byte is captured when its first bit is driven.
- R10: The power-up flag goes to 0 once a complete status byte has been shifted out. Nothing but reset sets it again.
- R11: In a read, a master acknowledge is followed by a fresh status byte. A master no-acknowledge leaves SDA released until the next start.
- R12: After a matched write address, the MSB of the first data byte sets the group: 0 means frequency, 1 means control. The byte after it is that group's second byte. The next byte is sorted again, so frequency-then-control and control-then-frequency orders both work within one transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rst_n | input | 1 | Active-low power-on reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain) |
| addr_sel | input | 2 | Low two bits of the slave address |
| lock_i | input | 1 | Loop lock indication for the status byte |
| conv_code | input | 3 | Level code from the external converter |
| main_ratio | output | 13 | Main divider value M |
| swallow | output | 4 | Swallow counter value S |
| ref_code | output | 4 | Reference divider code R |
| pre_half | output | 1 | Prescaler divide-by-two enable (PE) |
| cp_hi | output | 1 | Charge-pump current select (CP) |
| vari_off | output | 1 | Varicap drive off (OS) |
| port_bits | output | 4 | General port bits P4..P1 |

## Verification
The status-byte capture and a change on lock_i can fall in the same system-clock cycle. The clearing of the power-up flag and the loading of the next status byte also sit close together within a single read. The bench flips lock_i in the middle of the first byte of a two-byte read. It then expects that byte to carry the old lock value and a power-up flag of 1. It expects the second byte to show the new lock value with the flag already at 0.

// File: rtl/tuner_ctl_i2c_slave.sv
module tuner_ctl_i2c_slave #(
  parameter int         SYNC_STAGES = 2,
  parameter logic [4:0] ADDR_FIXED  = 5'b11000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe,
  input  logic [1:0]  addr_sel,
  input  logic        lock_i,
  input  logic [2:0]  conv_code,
  output logic [12:0] main_ratio,
  output logic [3:0]  swallow,
  output logic [3:0]  ref_code,
  output logic        pre_half,
  output logic        cp_hi,
  output logic        vari_off,
  output logic [3:0]  port_bits
);
  localparam logic [2:0] ST_IDLE = 3'd0, ST_ADDR = 3'd1, ST_WR = 3'd2, ST_RD = 3'd3, ST_SKIP = 3'd4;
  localparam logic [1:0] WP_FIRST = 2'd0, WP_FREQ2 = 2'd1, WP_CTRL2 = 2'd2;

  logic [SYNC_STAGES:0] scl_s, sda_s;
  logic scl_now, scl_old, sda_now, sda_old;
  logic scl_rise, scl_fall, bus_start, bus_stop;

  logic [2:0]  state;
  logic [3:0]  bitcnt;
  logic        ack_ph, mack, pr;
  logic [7:0]  sh, tx;
  logic [1:0]  wph;
  logic [6:0]  fhold;
  logic [1:0]  m_hi;
  logic [10:0] m_lo;
  logic [7:0]  status;
  logic        addr_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_s <= '1;
      sda_s <= '1;
    end else begin
      scl_s <= {scl_s[SYNC_STAGES-1:0], scl_i};
      sda_s <= {sda_s[SYNC_STAGES-1:0], sda_i};
    end
  end

  assign scl_now   = scl_s[SYNC_STAGES-1];
  assign scl_old   = scl_s[SYNC_STAGES];
  assign sda_now   = sda_s[SYNC_STAGES-1];
  assign sda_old   = sda_s[SYNC_STAGES];
  assign scl_rise  = scl_now & ~scl_old;
  assign scl_fall  = ~scl_now & scl_old;
  assign bus_start = scl_now & scl_old & ~sda_now & sda_old;
  assign bus_stop  = scl_now & scl_old & sda_now & ~sda_old;

  assign status     = {pr, lock_i, 3'b111, conv_code};
  assign addr_ok    = (sh[7:1] == {ADDR_FIXED, addr_sel});
  assign main_ratio = {m_hi, m_lo};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;  bitcnt <= '0;  ack_ph <= 1'b0;  mack <= 1'b0;
      sh <= '0;  tx <= '0;  wph <= WP_FIRST;  fhold <= '0;  pr <= 1'b1;
      sda_oe <= 1'b0;  m_hi <= '0;  m_lo <= '0;  swallow <= '0;  ref_code <= '0;
      pre_half <= 1'b0;  cp_hi <= 1'b0;  vari_off <= 1'b0;  port_bits <= '0;
    end else if (bus_start) begin
      state <= ST_ADDR;  bitcnt <= '0;  ack_ph <= 1'b0;  sda_oe <= 1'b0;
    end else if (bus_stop) begin
      state <= ST_IDLE;  ack_ph <= 1'b0;  sda_oe <= 1'b0;
    end else if (state != ST_IDLE) begin
      if (scl_rise) begin
        if (ack_ph) mack <= ~sda_now;
        else begin
          sh     <= {sh[6:0], sda_now};
          bitcnt <= bitcnt + 4'd1;
        end
      end else if (scl_fall) begin
        if (ack_ph) begin
          ack_ph <= 1'b0;
          bitcnt <= '0;
          sda_oe <= 1'b0;
          if (state == ST_RD) begin
            if (mack) begin
              tx     <= status;
              sda_oe <= ~status[7];
            end else state <= ST_SKIP;
          end
        end else if (bitcnt == 4'd8) begin
          ack_ph <= 1'b1;
          case (state)
            ST_ADDR: begin
              if (addr_ok) begin
                sda_oe <= 1'b1;
                wph    <= WP_FIRST;
                state  <= sh[0] ? ST_RD : ST_WR;
              end else state <= ST_SKIP;
            end
            ST_WR: begin
              sda_oe <= 1'b1;
              case (wph)
                WP_FIRST: begin
                  if (!sh[7]) begin
                    fhold <= sh[6:0];
                    wph   <= WP_FREQ2;
                  end else begin
                    m_hi     <= sh[6:5];
                    pre_half <= sh[4];
                    ref_code <= sh[3:0];
                    wph      <= WP_CTRL2;
                  end
                end
                WP_FREQ2: begin
                  m_lo    <= {fhold, sh[7:4]};
                  swallow <= sh[3:0];
                  wph     <= WP_FIRST;
                end
                default: begin
                  vari_off  <= sh[7];
                  cp_hi     <= sh[6];
                  port_bits <= sh[3:0];
                  wph       <= WP_FIRST;
                end
              endcase
            end
            ST_RD: begin
              sda_oe <= 1'b0;
              pr     <= 1'b0;
            end
            default: ;
          endcase
        end else if (state == ST_RD && bitcnt != 4'd0) begin
          sda_oe <= ~tx[6];
          tx     <= {tx[6:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/tuner_ctl_i2c_slave_chk.sv
module tuner_ctl_i2c_slave_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sda_oe,
  input logic [2:0]  state,
  input logic        ack_ph,
  input logic        scl_lvl,
  input logic        pr,
  input logic [27:0] outs
);
  localparam logic [2:0] C_WR = 3'd2, C_RD = 3'd3, C_SKIP = 3'd4;

  AST_PULL_WHILE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_lvl); // R3
  AST_WRITE_PULL_IS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (state == C_WR && $rose(sda_oe)) |-> ack_ph); // R3
  AST_COMMIT_AT_BYTE_END: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(outs) |-> $rose(ack_ph)); // R4
  AST_FLAG_NEVER_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(pr)); // R10
  AST_FLAG_CLEARS_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pr) |-> (state == C_RD)); // R10
  AST_SKIP_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == C_SKIP) |-> !sda_oe); // R11
endmodule

bind tuner_ctl_i2c_slave tuner_ctl_i2c_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .state(state), .ack_ph(ack_ph),
  .scl_lvl(scl_now), .pr(pr),
  .outs({main_ratio, swallow, ref_code, pre_half, cp_hi, vari_off, port_bits})
);

// File: tb/tb_tuner_ctl_i2c_slave.sv
module tb_tuner_ctl_i2c_slave;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1;
  logic [1:0]  sel = 2'd2;
  logic        lock = 1'b0;
  logic [2:0]  code = 3'd5;
  logic        sda_oe, sda_line;
  logic [12:0] main_ratio;
  logic [3:0]  swallow, ref_code, port_bits;
  logic        pre_half, cp_hi, vari_off;

  assign sda_line = sda_m & ~sda_oe;

  tuner_ctl_i2c_slave dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .addr_sel(sel), .lock_i(lock), .conv_code(code), .main_ratio(main_ratio),
    .swallow(swallow), .ref_code(ref_code), .pre_half(pre_half), .cp_hi(cp_hi),
    .vari_off(vari_off), .port_bits(port_bits));

  int ncmp = 0, nbad = 0;
  logic [1:0]  em_hi = '0;
  logic [10:0] em_lo = '0;
  logic [3:0]  es = '0, er = '0, ep = '0;
  logic        epe = 0, ecp = 0, eos = 0, epr = 1;
  logic [7:0]  wb [0:4];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    ncmp++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] f1(input logic [10:0] m); return {1'b0, m[10:4]}; endfunction
  function automatic logic [7:0] f2(input logic [10:0] m, input logic [3:0] s); return {m[3:0], s}; endfunction
  function automatic logic [7:0] c1(input logic [1:0] mh, input logic pe, input logic [3:0] r); return {1'b1, mh, pe, r}; endfunction
  function automatic logic [7:0] c2(input logic os, input logic cp, input logic [3:0] p); return {os, cp, 2'b00, p}; endfunction
  function automatic logic [7:0] stat(input logic f, input logic l, input logic [2:0] c); return {f, l, 3'b111, c}; endfunction
  function automatic logic [7:0] adr(input logic [1:0] s, input logic rw); return {5'b11000, s, rw}; endfunction

  function automatic logic [27:0] exp_outs();
    return {em_hi, em_lo, es, er, epe, ecp, eos, ep};
  endfunction
  function automatic logic [27:0] act_outs();
    return {main_ratio, swallow, ref_code, pre_half, cp_hi, vari_off, port_bits};
  endfunction

  task automatic q(); repeat (6) @(negedge clk); endtask
  task automatic bstart(); sda_m = 1; q(); scl_m = 1; q(); sda_m = 0; q(); scl_m = 0; q(); endtask
  task automatic bstop();  sda_m = 0; q(); scl_m = 1; q(); sda_m = 1; q(); endtask
  task automatic wbit(input logic b); sda_m = b; q(); scl_m = 1; q(); q(); scl_m = 0; q(); endtask
  task automatic rbit(output logic b); sda_m = 1; q(); scl_m = 1; q(); b = sda_line; q(); scl_m = 0; q(); endtask

  task automatic send_byte(input logic [7:0] b, output int ak);
    logic a;
    for (int j = 7; j >= 0; j--) wbit(b[j]);
    rbit(a);
    ak = a ? 0 : 1;
  endtask

  task automatic wr(input logic [7:0] a, input int n, input bit do_stop, output int acks);
    int ak;
    bstart();
    send_byte(a, ak); acks = ak;
    for (int i = 0; i < n; i++) begin send_byte(wb[i], ak); acks += ak; end
    if (do_stop) bstop();
  endtask

  task automatic rd(input int n, input bit flip, input bit probe,
                    output logic [7:0] b0, output logic [7:0] b1, output int ak, output int lowseen);
    logic bt;
    logic [7:0] v;
    bstart();
    send_byte(adr(sel, 1'b1), ak);
    b0 = '0; b1 = '0; lowseen = 0;
    for (int i = 0; i < n; i++) begin
      v = '0;
      for (int j = 0; j < 8; j++) begin
        rbit(bt); v = {v[6:0], bt};
        if (flip && i == 0 && j == 3) lock = ~lock;
      end
      wbit(i == n - 1);
      if (i == 0) b0 = v; else b1 = v;
    end
    if (probe) for (int k = 0; k < 9; k++) begin rbit(bt); if (!bt) lowseen++; end
    bstop();
  endtask

  initial begin
    int acks, ak, low, op;
    logic [7:0] r0, r1;
    logic [10:0] m;
    logic [3:0] s, r, p;
    logic [1:0] mh;
    logic lk0;
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {4'h0, act_outs()}, 32'h0);
    chk("R1 reset sda released", {31'd0, sda_oe}, 32'd0);

    lk0 = lock;
    rd(2, 1'b1, 1'b0, r0, r1, ak, low);
    chk("R9 status byte with flag set", {24'd0, r0}, {24'd0, stat(1'b1, lk0, code)});
    chk("R10 flag clear in second byte, new lock", {24'd0, r1}, {24'd0, stat(1'b0, ~lk0, code)});
    epr = 0;

    m = 11'h5A3; s = 4'hC; mh = 2'b10; r = 4'h9; p = 4'hA;
    wb[0] = f1(m); wb[1] = f2(m, s); wb[2] = c1(mh, 1'b1, r); wb[3] = c2(1'b1, 1'b0, p);
    wr(adr(sel, 1'b0), 4, 1'b1, acks);
    em_lo = m; es = s; em_hi = mh; epe = 1; er = r; eos = 1; ecp = 0; ep = p;
    chk("R3 five-byte write acked", acks, 5);
    chk("R12 freq-then-control order", {4'h0, act_outs()}, {4'h0, exp_outs()});

    m = 11'h0F1; s = 4'h3; mh = 2'b01; r = 4'h4; p = 4'h5;
    wb[0] = c1(mh, 1'b0, r); wb[1] = c2(1'b0, 1'b1, p); wb[2] = f1(m); wb[3] = f2(m, s);
    wr(adr(sel, 1'b0), 4, 1'b1, acks);
    em_lo = m; es = s; em_hi = mh; epe = 0; er = r; eos = 0; ecp = 1; ep = p;
    chk("R12 control-then-freq order", {4'h0, act_outs()}, {4'h0, exp_outs()});

    wb[0] = f1(11'h7FF);
    wr(adr(sel, 1'b0), 1, 1'b1, acks);
    chk("R7 partial freq keeps outputs", {4'h0, act_outs()}, {4'h0, exp_outs()});

    wb[0] = c1(2'b11, 1'b1, 4'hF);
    wr(adr(sel, 1'b0), 1, 1'b1, acks);
    em_hi = 2'b11; epe = 1; er = 4'hF;
    chk("R5 lone control byte A commits", {4'h0, act_outs()}, {4'h0, exp_outs()});

    wb[0] = f1(11'h123); wb[1] = f2(11'h123, 4'h1);
    wr(adr(sel ^ 2'b01, 1'b0), 2, 1'b1, acks);
    chk("R2 foreign address not acked", acks, 0);
    chk("R2 foreign address no effect", {4'h0, act_outs()}, {4'h0, exp_outs()});

    wb[0] = f1(11'h400);
    wr(adr(sel, 1'b0), 1, 1'b0, acks);
    m = 11'h2B6; s = 4'h7;
    wb[0] = f1(m); wb[1] = f2(m, s);
    wr(adr(sel, 1'b0), 2, 1'b1, acks);
    em_lo = m; es = s;
    chk("R8 repeated start acked", acks, 3);
    chk("R8 repeated start updates", {4'h0, act_outs()}, {4'h0, exp_outs()});

    rd(1, 1'b0, 1'b1, r0, r1, ak, low);
    chk("R11 nack keeps sda released", low, 0);
    chk("R9 status after clear", {24'd0, r0}, {24'd0, stat(1'b0, lock, code)});

    for (int it = 0; it < 40; it++) begin
      if (it % 10 == 5) sel = 2'($urandom);
      op = $urandom_range(0, 4);
      m = 11'($urandom); s = 4'($urandom); mh = 2'($urandom); r = 4'($urandom); p = 4'($urandom);
      case (op)
        0: begin
          wb[0] = f1(m); wb[1] = f2(m, s);
          wr(adr(sel, 1'b0), 2, 1'b1, acks);
          em_lo = m; es = s;
          chk("R4 random freq pair acks", acks, 3);
        end
        1: begin
          wb[0] = c1(mh, p[0], r); wb[1] = c2(p[1], p[2], s);
          wr(adr(sel, 1'b0), 2, 1'b1, acks);
          em_hi = mh; epe = p[0]; er = r; eos = p[1]; ecp = p[2]; ep = s;
          chk("R6 random control pair acks", acks, 3);
        end
        2: begin
          wb[0] = f1(m);
          wr(adr(sel, 1'b0), 1, 1'b1, acks);
          chk("R7 random partial acks", acks, 2);
        end
        3: begin
          wb[0] = f1(m); wb[1] = f2(m, s);
          wr(adr(sel ^ (2'($urandom_range(1, 3))), 1'b0), 2, 1'b1, acks);
          chk("R2 random foreign acks", acks, 0);
        end
        default: begin
          lock = 1'($urandom); code = 3'($urandom);
          rd(1, 1'b0, 1'b0, r0, r1, ak, low);
          chk("R9 random status", {24'd0, r0}, {24'd0, stat(1'b0, lock, code)});
        end
      endcase
      chk("R4 random outputs", {4'h0, act_outs()}, {4'h0, exp_outs()});
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    ncmp++; nbad++;
    $display("FAIL watchdog R1..R12 run: actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
    $finish;
  end
endmodule